// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synthesizable model of a synchronous pipelined SRAM. It needs no dead cycles when the bus switches between reads and writes. The storage is a small register file, 256 words of 32 bits at the default parameters. A command is taken on a rising clock edge. Read data leaves the output register two edges later. Write data is sampled two edges after its command. Because the data phase lags the command by the same amount for both directions, reads and writes can alternate on every cycle and the data bus stays fully used.

Commands can start a single access or a four-beat burst, and the burst wraps inside an aligned block of four words. A parameter chooses between a linear and an XOR-interleaved burst order. Writes are byte-granular. Other controls are:
- A clock enable freezes the whole pipeline.
- An asynchronous output enable gates the read data.
- A sleep input puts the block into a retention state, with fixed entry and wake-up delays.

A read issued right after a write to the same word sees the merged write data, because the write data is bypassed into the read.

Top module: `pipe_burst_sram`

## Requirements
- R1: A command is taken at a rising edge with `cke_n` low, `adv` low and `sel` high, and `addr` and `we_n` are captured at that edge. With `sel` low the edge is a deselect. Continue edges (`adv` high) that follow a deselect stay deselected and drive no data.
- R2: For a read taken at edge k, the word is on `rdata` with `rvalid` high after edge k+2, and not after edge k+1.
- R3: For a write taken at edge k, `wdata` is sampled at edge k+2 and stored at the captured address. Reads and writes may be issued on consecutive edges.
- R4: `bw_n[i]` low writes only bits [8i+7:8i]. The byte enables are sampled at the command or continue edge. A write with all four `bw_n` bits high leaves the word unchanged.
- R5: A continue edge (`adv` high, after a taken command) moves to the next beat. Only the two low address bits step, and they wrap after four beats. With the linear order (default) beat n uses low bits (start+n) mod 4. With the interleaved order it uses start XOR n.
- R6: At an edge with `cke_n` high, all synchronous inputs are ignored and every pipeline and output register keeps its value.
- R7: `rvalid` is high exactly while the output register holds read data and `oe_n` is low. It reacts to `oe_n` with no clock edge. `rdata` is zero whenever `rvalid` is low. A read made while `oe_n` is held high (a dummy read) drives nothing.
- R8: A read taken one edge after a write to the same address returns the old word with that write's enabled bytes merged in.
- R9: After `sleep_req` is sampled high at two consecutive edges, the block is asleep. Commands at later edges are ignored while the array contents are kept. The command at the second of those two edges is still taken.
- R10: After `sleep_req` is sampled low at two consecutive edges, commands at those two edges are ignored. Commands are taken again from the next edge.
- R11: `rst` high at an edge clears the pipeline to the deselected state: `rvalid` goes low and a pending write is dropped. The array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low |
| sel | input | 1 | Combined chip select, active high |
| adv | input | 1 | High: continue burst; low: take new command |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | 4 | Byte lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data, two edges after its command |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
The assertions assume that reset is held high for the first edges and that every control input has a known value at each edge. They also assume that `sleep_req` and `cke_n` do not change between edges, apart from `oe_n`, which is allowed to move at any time. The stimulus changes all inputs on the falling edge and keeps reset high for the first three edges. It moves `oe_n` mid-cycle only to test the asynchronous gating. Every write's data is placed on the bus in exactly the cycle that its command's latency requires.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;

   typedef enum logic [1:0] {
      SL_RUN   = 2'd0,
      SL_ENTER = 2'd1,
      SL_SLEEP = 2'd2,
      SL_WAKE  = 2'd3
   } slp_e;

endpackage

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq #(
   parameter int CNT_W  = 2,
   parameter bit LINEAR = 1'b1
) (
   input  logic [CNT_W-1:0] start,
   input  logic [CNT_W-1:0] step,
   output logic [CNT_W-1:0] lo
);

   generate
      if (LINEAR) begin : g_linear
         assign lo = start + step;
      end else begin : g_xor
         assign lo = start ^ step;
      end
   endgenerate

endmodule

// File: rtl/pbs_sleep_ctl.sv
module pbs_sleep_ctl
   import pbs_pkg::*;
#(
   parameter int ENTER_CYC = 2,
   parameter int WAKE_CYC  = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sleep_req,
   output logic accept
);

   localparam int MAXC = (ENTER_CYC > WAKE_CYC) ? ENTER_CYC : WAKE_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   slp_e          st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= SL_RUN;
         cnt <= '0;
      end else begin
         case (st)
            SL_RUN: if (sleep_req) begin
               cnt <= CW'(1);
               st  <= (ENTER_CYC == 1) ? SL_SLEEP : SL_ENTER;
            end
            SL_ENTER: if (!sleep_req) st <= SL_RUN;
                      else if (cnt == CW'(ENTER_CYC - 1)) st <= SL_SLEEP;
                      else cnt <= cnt + CW'(1);
            SL_SLEEP: if (!sleep_req) begin
               cnt <= CW'(1);
               st  <= (WAKE_CYC == 1) ? SL_RUN : SL_WAKE;
            end
            default: if (sleep_req) st <= SL_SLEEP;
                     else if (cnt == CW'(WAKE_CYC - 1)) st <= SL_RUN;
                     else cnt <= cnt + CW'(1);
         endcase
      end
   end

   assign accept = (st == SL_RUN) || (st == SL_ENTER);

   AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst) (st == SL_SLEEP && !sleep_req) |=> !accept); // R10

endmodule

// File: rtl/pbs_cmd_pipe.sv
module pbs_cmd_pipe
   import pbs_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int LANES   = 4,
   parameter int BURST_W = 2,
   parameter bit LINEAR  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cke_n,
   input  logic              accept,
   input  logic              sel,
   input  logic              adv,
   input  logic              we_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr,
   output op_e               op1,
   output logic [ADDR_W-1:0] addr1,
   output op_e               op2,
   output logic [ADDR_W-1:0] addr2,
   output logic [LANES-1:0]  bw2
);

   logic [LANES-1:0]   bw1;
   logic [BURST_W-1:0] start1, cnt1, step_nx, nxt_lo;

   assign step_nx = cnt1 + BURST_W'(1);

   pbs_burst_seq #(.CNT_W(BURST_W), .LINEAR(LINEAR)) u_seq (
      .start (start1),
      .step  (step_nx),
      .lo    (nxt_lo)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         op1    <= OP_IDLE;
         op2    <= OP_IDLE;
         addr1  <= '0;
         addr2  <= '0;
         bw1    <= '1;
         bw2    <= '1;
         start1 <= '0;
         cnt1   <= '0;
      end else if (!cke_n) begin
         op2   <= op1;
         addr2 <= addr1;
         bw2   <= bw1;
         if (!adv) begin
            if (accept && sel) begin
               op1    <= we_n ? OP_RD : OP_WR;
               addr1  <= addr;
               start1 <= addr[BURST_W-1:0];
               cnt1   <= '0;
               bw1    <= bw_n;
            end else begin
               op1 <= OP_IDLE;
            end
         end else if (!accept) begin
            op1 <= OP_IDLE;
         end else if (op1 != OP_IDLE) begin
            addr1 <= {addr1[ADDR_W-1:BURST_W], nxt_lo};
            cnt1  <= step_nx;
            bw1   <= bw_n;
         end
      end
   end

   AST_BURST_PAGE: assert property (@(posedge clk) disable iff (rst) (!cke_n && adv && accept && op1 != OP_IDLE) |=> (addr1[ADDR_W-1:BURST_W] == $past(addr1[ADDR_W-1:BURST_W]))); // R5

endmodule

// File: rtl/pbs_store.sv
module pbs_store #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cke_n,
   input  logic [ADDR_W-1:0] raddr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANES-1:0]  wbw_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic              out_en,
   output logic [LANES*LANE_W-1:0] out_q,
   output logic              out_rd
);

   localparam int DW    = LANES * LANE_W;
   localparam int DEPTH = 1 << ADDR_W;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_raw, rd_merged, hold_q;
   logic          hit;

   assign rd_raw = mem[raddr];
   assign hit    = wr_en && (waddr == raddr);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign rd_merged[g*LANE_W +: LANE_W] = (hit && !wbw_n[g]) ?
                wdata[g*LANE_W +: LANE_W] : rd_raw[g*LANE_W +: LANE_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst && !cke_n && wr_en) begin
         for (int i = 0; i < LANES; i++) begin
            if (!wbw_n[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
         out_q  <= '0;
         out_rd <= 1'b0;
      end else if (!cke_n) begin
         hold_q <= rd_merged;
         out_q  <= hold_q;
         out_rd <= out_en;
      end
   end

   AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (rst) (!cke_n && wr_en && (&wbw_n)) |=> (mem[$past(waddr)] == $past(mem[waddr]))); // R4

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
   import pbs_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int LANES        = 4,
   parameter int LANE_W       = 8,
   parameter int BURST_W      = 2,
   parameter bit LINEAR_BURST = 1'b1,
   parameter int ENTER_CYC    = 2,
   parameter int WAKE_CYC     = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    cke_n,
   input  logic                    sel,
   input  logic                    adv,
   input  logic                    we_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    oe_n,
   input  logic                    sleep_req,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rvalid
);

   localparam int DW = LANES * LANE_W;

   generate
      if (BURST_W < 1 || BURST_W > ADDR_W) begin : g_bad_burst
         $error("burst counter width must lie between 1 and the address width");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("lane count and lane width must be positive");
      end
      if (ENTER_CYC < 1 || WAKE_CYC < 1) begin : g_bad_sleep
         $error("sleep entry and wake delays must be at least one cycle");
      end
   endgenerate

   logic              acc;
   op_e               op1, op2;
   logic [ADDR_W-1:0] addr1, addr2;
   logic [LANES-1:0]  bw2;
   logic [DW-1:0]     out_q;
   logic              out_rd;

   pbs_sleep_ctl #(.ENTER_CYC(ENTER_CYC), .WAKE_CYC(WAKE_CYC)) u_sleep (
      .clk       (clk),
      .rst       (rst),
      .sleep_req (sleep_req),
      .accept    (acc)
   );

   pbs_cmd_pipe #(
      .ADDR_W  (ADDR_W),
      .LANES   (LANES),
      .BURST_W (BURST_W),
      .LINEAR  (LINEAR_BURST)
   ) u_pipe (
      .clk    (clk),
      .rst    (rst),
      .cke_n  (cke_n),
      .accept (acc),
      .sel    (sel),
      .adv    (adv),
      .we_n   (we_n),
      .bw_n   (bw_n),
      .addr   (addr),
      .op1    (op1),
      .addr1  (addr1),
      .op2    (op2),
      .addr2  (addr2),
      .bw2    (bw2)
   );

   pbs_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk    (clk),
      .rst    (rst),
      .cke_n  (cke_n),
      .raddr  (addr1),
      .wr_en  (op2 == OP_WR),
      .waddr  (addr2),
      .wbw_n  (bw2),
      .wdata  (wdata),
      .out_en (op2 == OP_RD),
      .out_q  (out_q),
      .out_rd (out_rd)
   );

   assign rvalid = out_rd & ~oe_n;
   assign rdata  = rvalid ? out_q : '0;

   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst) cke_n |=> ($stable(out_q) && $stable(out_rd) && $stable(op1) && $stable(op2) && $stable(addr1))); // R6
   AST_ASLEEP_IDLE: assert property (@(posedge clk) disable iff (rst) (!acc && !cke_n) |=> (op1 == OP_IDLE)); // R9
   AST_READ_ORIGIN: assert property (@(posedge clk) disable iff (rst) $rose(out_rd) |-> $past(op2 == OP_RD)); // R2
   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (op1 == OP_IDLE && op2 == OP_IDLE && !out_rd)); // R11

endmodule

// File: tb/pipe_burst_sram_test.sv
module pipe_burst_sram_test;

   logic        clk = 1'b0;
   logic        rst, cke_n, sel, adv, we_n, oe_n, sleep_req;
   logic [3:0]  bw_n;
   logic [7:0]  addr;
   logic [31:0] wdata, rdata;
   logic        rvalid;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [31:0] model [256];

   always #4 clk = ~clk;

   pipe_burst_sram uut (
      .clk(clk), .rst(rst), .cke_n(cke_n), .sel(sel), .adv(adv), .we_n(we_n),
      .bw_n(bw_n), .oe_n(oe_n), .sleep_req(sleep_req), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
   );

   function automatic logic [31:0] mrg(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] b);
      logic [31:0] r = old;
      for (int i = 0; i < 4; i++) if (!b[i]) r[i*8 +: 8] = nw[i*8 +: 8];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic cyc(input logic s, input logic a, input logic w, input logic [3:0] b,
                      input logic [7:0] ad, input logic [31:0] wd);
      sel = s; adv = a; we_n = w; bw_n = b; addr = ad; wdata = wd;
      @(negedge clk);
   endtask

   task automatic idle(input logic [31:0] wd);
      cyc(1'b0, 1'b0, 1'b1, 4'hF, 8'h00, wd);
   endtask

   task automatic wr1(input logic [7:0] ad, input logic [31:0] d, input logic [3:0] b);
      cyc(1'b1, 1'b0, 1'b0, b, ad, 32'h0);
      idle(32'h0);
      idle(d);
      model[ad] = mrg(model[ad], d, b);
   endtask

   task automatic rd1(input logic [7:0] ad, input string req);
      cyc(1'b1, 1'b0, 1'b1, 4'hF, ad, 32'h0);
      idle(32'h0);
      chk({req, " R2 not early"}, {31'b0, rvalid}, 32'd0);
      idle(32'h0);
      chk({req, " R2 valid"}, {31'b0, rvalid}, 32'd1);
      chk(req, rdata, model[ad]);
   endtask

   task automatic t_reset_state;
      chk("R11 rvalid after reset", {31'b0, rvalid}, 32'd0);
      chk("R7 rdata zero after reset", rdata, 32'h0);
   endtask

   task automatic t_single;
      wr1(8'h10, 32'hA5A5_0001, 4'h0);
      rd1(8'h10, "R1 R3 single write/read");
   endtask

   task automatic t_interleave;
      logic [31:0] o31, m31;
      wr1(8'h30, 32'h3030_3030, 4'h0);
      wr1(8'h31, 32'h3131_3131, 4'h0);
      o31 = model[8'h31];
      m31 = mrg(o31, 32'hDEAD_BEEF, 4'b1100);
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h30, 32'h0);           // c0 write 0x30
      cyc(1'b1, 1'b0, 1'b1, 4'hF, 8'h31, 32'h0);           // c1 read 0x31
      cyc(1'b1, 1'b0, 1'b0, 4'b1100, 8'h31, 32'h0BAD_F00D); // c2 write 0x31, data of c0
      cyc(1'b1, 1'b0, 1'b1, 4'hF, 8'h31, 32'h0);           // c3 read 0x31 (bypass)
      chk("R2 interleave read old", rdata, o31);
      cyc(1'b1, 1'b0, 1'b1, 4'hF, 8'h30, 32'hDEAD_BEEF);   // c4 read 0x30, data of c2
      idle(32'h0);                                          // c5
      chk("R8 read after write merged", rdata, m31);
      idle(32'h0);                                          // c6
      chk("R3 write data two edges later", rdata, 32'h0BAD_F00D);
      model[8'h30] = 32'h0BAD_F00D;
      model[8'h31] = m31;
      idle(32'h0);
   endtask

   task automatic t_bytes;
      wr1(8'h40, 32'h1122_3344, 4'h0);
      wr1(8'h40, 32'hAABB_CCDD, 4'b1010);
      wr1(8'h40, 32'hFFFF_FFFF, 4'hF);
      cyc(1'b1, 1'b0, 1'b1, 4'hF, 8'h40, 32'h0);
      idle(32'h0);
      idle(32'h0);
      chk("R4 lanes 0,2 written, abort ignored", rdata, 32'h11BB_33DD);
   endtask

   task automatic t_burst;
      logic [31:0] bd [4];
      for (int n = 0; n < 4; n++) bd[n] = 32'hB0B0_0000 + 32'(n);
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h21, 32'h0);
      cyc(1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 32'h0);
      cyc(1'b0, 1'b1, 1'b0, 4'h0, 8'h00, bd[0]);
      cyc(1'b0, 1'b1, 1'b0, 4'h0, 8'h00, bd[1]);
      idle(bd[2]);
      idle(bd[3]);
      for (int n = 0; n < 4; n++) model[8'h20 + 8'((1 + n) % 4)] = bd[n];
      rd1(8'h21, "R5 burst beat 0");
      rd1(8'h22, "R5 burst beat 1");
      rd1(8'h23, "R5 burst beat 2");
      rd1(8'h20, "R5 burst beat 3 wrapped");
      for (int i = 0; i < 7; i++) begin
         if (i == 0)     cyc(1'b1, 1'b0, 1'b1, 4'hF, 8'h22, 32'h0);
         else if (i < 5) cyc(1'b0, 1'b1, 1'b1, 4'hF, 8'h00, 32'h0);
         else            idle(32'h0);
         if (i >= 2) chk("R5 read burst wrap", rdata, model[8'h20 + 8'((2 + i - 2) % 4)]);
      end
   endtask

   task automatic t_deselect;
      idle(32'h0);
      for (int i = 0; i < 4; i++) begin
         cyc(1'b1, 1'b1, 1'b1, 4'hF, 8'h10, 32'h0);
         chk("R1 continue after deselect", {31'b0, rvalid}, 32'd0);
      end
      idle(32'h0);
      idle(32'h0);
      chk("R1 continue after deselect drained", {31'b0, rvalid}, 32'd0);
   endtask

   task automatic t_stall;
      wr1(8'h50, 32'h5050_AAAA, 4'h0);
      wr1(8'h51, 32'h5151_BBBB, 4'h0);
      cyc(1'b1, 1'b0, 1'b1, 4'hF, 8'h50, 32'h0);  // s0 read
      cke_n = 1'b1;
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h51, 32'h0);  // s1 write ignored
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h51, 32'h0);  // s2
      cke_n = 1'b0;
      idle(32'hFFFF_0000);                         // s3
      chk("R6 stall delays read", {31'b0, rvalid}, 32'd0);
      idle(32'hFFFF_0000);                         // s4
      chk("R6 read after stall", rdata, model[8'h50]);
      cke_n = 1'b1;
      idle(32'h0);                                 // s5
      chk("R6 output held in stall", rdata, model[8'h50]);
      chk("R6 valid held in stall", {31'b0, rvalid}, 32'd1);
      cke_n = 1'b0;
      idle(32'h0);
      idle(32'h0);
      rd1(8'h51, "R6 write during stall ignored");
   endtask

   task automatic t_oe;
      wr1(8'h60, 32'h6060_1234, 4'h0);
      cyc(1'b1, 1'b0, 1'b1, 4'hF, 8'h60, 32'h0);
      idle(32'h0);
      oe_n = 1'b1;
      idle(32'h0);
      chk("R7 oe high blocks valid", {31'b0, rvalid}, 32'd0);
      chk("R7 oe high zero data", rdata, 32'h0);
      #1 oe_n = 1'b0;
      #1;
      chk("R7 async oe valid", {31'b0, rvalid}, 32'd1);
      chk("R7 async oe data", rdata, model[8'h60]);
      @(negedge clk);
      oe_n = 1'b1;
      cyc(1'b1, 1'b0, 1'b1, 4'hF, 8'h60, 32'h0);
      idle(32'h0);
      idle(32'h0);
      chk("R7 dummy read drives nothing", {31'b0, rvalid}, 32'd0);
      idle(32'h0);
      oe_n = 1'b0;
   endtask

   task automatic t_sleep;
      for (int i = 0; i < 5; i++) wr1(8'h70 + 8'(i), 32'h7000_0000 + 32'(i), 4'h0);
      sleep_req = 1'b1;
      idle(32'h0);                                         // j0
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h70, 32'h0);           // j1 taken
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h71, 32'h0);           // j2 asleep
      sleep_req = 1'b0;
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h72, 32'hE700_0070);   // j3 wake 1, data of j1
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h73, 32'h1111_1111);   // j4 wake 2
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h74, 32'h2222_2222);   // j5 taken
      idle(32'h3333_3333);
      idle(32'hE700_0074);
      model[8'h70] = 32'hE700_0070;
      model[8'h74] = 32'hE700_0074;
      rd1(8'h70, "R9 command on second sleep edge taken");
      rd1(8'h71, "R9 command while asleep ignored");
      rd1(8'h72, "R10 first wake edge ignored");
      rd1(8'h73, "R10 second wake edge ignored");
      rd1(8'h74, "R10 command after wake taken");
   endtask

   task automatic t_reset_mid;
      wr1(8'h80, 32'h8080_8080, 4'h0);
      cyc(1'b1, 1'b0, 1'b1, 4'hF, 8'h40, 32'h0);  // read in flight
      cyc(1'b1, 1'b0, 1'b0, 4'h0, 8'h80, 32'h0);  // write pending
      rst = 1'b1;
      idle(32'h0);
      rst = 1'b0;
      chk("R11 reset drops read", {31'b0, rvalid}, 32'd0);
      idle(32'h9999_9999);
      idle(32'h9999_9999);
      chk("R11 pipeline empty", {31'b0, rvalid}, 32'd0);
      rd1(8'h80, "R11 pending write dropped");
      rd1(8'h40, "R11 array kept");
   endtask

   initial begin
      rst = 1'b1; cke_n = 1'b0; sel = 1'b0; adv = 1'b0; we_n = 1'b1; bw_n = 4'hF;
      oe_n = 1'b0; sleep_req = 1'b0; addr = 8'h00; wdata = 32'h0;
      @(negedge clk); @(negedge clk); @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_single();
      t_interleave();
      t_bytes();
      t_burst();
      t_deselect();
      t_stall();
      t_oe();
      t_sleep();
      t_reset_mid();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 got=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule